// File: doc/BRIEF.md
# Prioritised Event Code Serial Encoder

This block collects timing event requests and sends each one as an 8-bit event code over a single serial timing link. There are 256 possible codes. Each code has its own hardware request line, and any code can also be requested by a software strobe that carries the code number. Every request is latched into a sticky pending bit. A request therefore survives while the link is busy, even if it lasted only one clock.

When the link is idle, the block takes the lowest-numbered pending code and starts one event slot for it. The lowest number has the highest priority. The lines are grouped into banks of 16, so the selection first finds the first bank with work and then the first line inside that bank. Taking a code clears its pending bit. A slot that has started always runs to its end. A higher-priority request that arrives during a slot waits for the next one.

The link runs at one bit per `BIT_DIV` clocks. With the default of 10 and a 100 MHz core clock, that gives a 10 MHz link bit rate. A busy flag and a count of pending codes let the host see when the link has drained.

Top module: `evl_encoder`

## Requirements
- R1: A rising edge on `req_i[n]`, held for at least one clock, queues code n once. A level that stays high produces only one event.
- R2: A one-clock `sw_valid_i` with code n on `sw_code_i` queues code n through the same pending bit as `req_i[n]`. A software request and a hardware request for the same code that are both pending produce one event.
- R3: When several codes are pending, the lowest code number is sent first. Ties across bank boundaries follow the code number too (0 before 15 before 16 before 255).
- R4: A slot in progress is never cut short. A higher-priority request that arrives during a slot is sent in the following slot.
- R5: A slot is sent in this order: a low start bit, the 8 code bits most significant first, an odd-parity bit (code plus parity holds an odd number of ones), and a high stop bit. Each bit lasts `BIT_DIV` clocks.
- R6: A code's pending bit clears when its slot starts. A new request for that code during its own slot is sent again afterwards.
- R7: Requests that arrive while the link is busy are all kept, including one-clock pulses on several lines at once, and each is sent later.
- R8: `busy_o` is high for exactly 11 × `BIT_DIV` clocks per slot.
- R9: `pend_cnt_o` equals the number of pending codes, one clock after the pending set changes.
- R10: After reset, `link_o` is high, `busy_o` is low and `pend_cnt_o` is zero. Between slots the link stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 256 | Hardware request lines, one per code, asynchronous |
| sw_valid_i | input | 1 | One-clock software request strobe |
| sw_code_i | input | 8 | Code requested by software |
| link_o | output | 1 | Serial timing link, idles high |
| busy_o | output | 1 | High while a slot is being sent |
| pend_cnt_o | output | 9 | Number of pending codes |

## Verification
The tests use the following request patterns, and each one separates a different kind of fault:

- **Single request.** One isolated request checks the slot format and parity by itself.
- **Simultaneous requests.** Pulses landing in one clock, including pulses that straddle bank boundaries, expose a wrong priority order or a bank-selection error.
- **Request during a slot, higher priority.** A higher-priority pulse during a slot shows whether the slot is preempted.
- **Request during a slot, same code.** A pulse on the code currently being sent shows whether the pending bit is cleared at the right moment.
- **Held level.** A request line held high separates edge detection from level sensing.
- **Software plus hardware for one code.** Both sources requesting the same code confirm that they share one pending bit.

The pending count is read in the middle of a slot, while queued requests are waiting.

// File: rtl/evl_pkg.sv
package evl_pkg;
  typedef enum logic [0:0] {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;

  // start + stop + parity around the code bits
  localparam int FRAME_OVERHEAD = 3;
endpackage

// File: rtl/evl_req_capture.sv
module evl_req_capture #(
  parameter int N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] sw_set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] sync1_q, sync2_q, prev_q, pend_q;
  logic [N-1:0] rise, pend_d;

  // rising edge of the synchronised line
  assign rise = sync2_q & ~prev_q;

  // a set in the same cycle as the clear wins, so the code is queued again
  always_comb begin
    pend_d = (pend_q & ~clr_i) | rise | sw_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      pend_q  <= '0;
    end else begin
      sync1_q <= req_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/evl_prio_pick.sv
module evl_prio_pick #(
  parameter int N    = 256,
  parameter int BANK = 16,
  localparam int NB     = N / BANK,
  localparam int LINE_W = $clog2(BANK),
  localparam int BANK_W = $clog2(NB),
  localparam int CODE_W = $clog2(N)
) (
  input  logic [N-1:0]      pend_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NB-1:0]        bank_any;
  logic [NB*LINE_W-1:0] bank_lines;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      logic [BANK-1:0]   slice;
      logic [LINE_W-1:0] first_line;

      assign slice = pend_i[b*BANK +: BANK];
      assign bank_any[b] = |slice;

      // lowest set line inside this bank
      always_comb begin
        first_line = '0;
        for (int i = BANK - 1; i >= 0; i--) begin
          if (slice[i]) first_line = LINE_W'(i);
        end
      end

      assign bank_lines[b*LINE_W +: LINE_W] = first_line;
    end
  endgenerate

  logic [BANK_W-1:0] sel_bank;

  // lowest bank that holds any pending line
  always_comb begin
    sel_bank = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (bank_any[k]) sel_bank = BANK_W'(k);
    end
  end

  assign valid_o = |bank_any;
  assign code_o  = {sel_bank, bank_lines[sel_bank*LINE_W +: LINE_W]};
endmodule

// File: rtl/evl_serializer.sv
module evl_serializer
  import evl_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int BIT_DIV = 10,
  localparam int FRAME_BITS = CODE_W + FRAME_OVERHEAD,
  localparam int DIV_W      = $clog2(BIT_DIV),
  localparam int BITN_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              link_o,
  output logic              busy_o
);
  ser_state_e              state_q, state_d;
  logic [FRAME_BITS-1:0]   frame_q, frame_d;
  logic [DIV_W-1:0]        div_q, div_d;
  logic [BITN_W-1:0]       bitn_q, bitn_d;
  logic                    frame_en, cnt_en;
  logic                    div_end, last_bit;

  assign div_end  = (div_q == DIV_W'(BIT_DIV - 1));
  assign last_bit = (bitn_q == BITN_W'(FRAME_BITS - 1));

  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    div_d    = div_q;
    bitn_d   = bitn_q;
    frame_en = 1'b0;
    cnt_en   = 1'b0;
    case (state_q)
      SER_IDLE: begin
        if (start_i) begin
          state_d  = SER_SEND;
          // start, code MSB first, odd parity, stop
          frame_d  = {1'b0, code_i, ~^code_i, 1'b1};
          div_d    = '0;
          bitn_d   = '0;
          frame_en = 1'b1;
          cnt_en   = 1'b1;
        end
      end
      SER_SEND: begin
        cnt_en = 1'b1;
        if (div_end) begin
          div_d = '0;
          if (last_bit) begin
            state_d = SER_IDLE;
          end else begin
            frame_d  = {frame_q[FRAME_BITS-2:0], 1'b1};
            frame_en = 1'b1;
            bitn_d   = bitn_q + 1'b1;
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: state_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      frame_q <= '1;
      div_q   <= '0;
      bitn_q  <= '0;
    end else begin
      state_q <= state_d;
      if (frame_en) frame_q <= frame_d;
      if (cnt_en) begin
        div_q  <= div_d;
        bitn_q <= bitn_d;
      end
    end
  end

  assign busy_o = (state_q == SER_SEND);
  assign link_o = busy_o ? frame_q[FRAME_BITS-1] : 1'b1;
endmodule

// File: rtl/evl_pend_count.sv
module evl_pend_count #(
  parameter int N = 256,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < N; i++) begin
      cnt_d = cnt_d + CNT_W'(pend_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evl_encoder.sv
module evl_encoder #(
  parameter int NUM_EVT = 256,
  parameter int BANK    = 16,
  parameter int BIT_DIV = 10,
  localparam int CODE_W = $clog2(NUM_EVT),
  localparam int CNT_W  = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] req_i,
  input  logic               sw_valid_i,
  input  logic [CODE_W-1:0]  sw_code_i,
  output logic               link_o,
  output logic               busy_o,
  output logic [CNT_W-1:0]   pend_cnt_o
);
  logic [NUM_EVT-1:0] sw_set, clr_vec, pend;
  logic               pick_valid, launch, ser_busy;
  logic [CODE_W-1:0]  pick_code;

  // software code decoded onto the same pending bits as the lines
  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      sw_set[i]  = sw_valid_i && (sw_code_i == CODE_W'(i));
      clr_vec[i] = launch && (pick_code == CODE_W'(i));
    end
  end

  // start a slot only while the link is idle; no preemption
  assign launch = pick_valid && !ser_busy;

  evl_req_capture #(.N(NUM_EVT)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .sw_set_i (sw_set),
    .clr_i    (clr_vec),
    .pend_o   (pend)
  );

  evl_prio_pick #(.N(NUM_EVT), .BANK(BANK)) u_pick (
    .pend_i  (pend),
    .valid_o (pick_valid),
    .code_o  (pick_code)
  );

  evl_serializer #(.CODE_W(CODE_W), .BIT_DIV(BIT_DIV)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (launch),
    .code_i  (pick_code),
    .link_o  (link_o),
    .busy_o  (ser_busy)
  );

  evl_pend_count #(.N(NUM_EVT)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .cnt_o  (pend_cnt_o)
  );

  assign busy_o = ser_busy;
endmodule

// File: rtl/evl_encoder_chk.sv
module evl_encoder_chk #(
  parameter int NUM_EVT    = 256,
  parameter int BIT_DIV    = 10,
  parameter int FRAME_BITS = 11,
  localparam int CNT_W = $clog2(NUM_EVT + 1),
  localparam int CYC_W = $clog2(FRAME_BITS * BIT_DIV + 2) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               link_o,
  input logic               busy_o,
  input logic [CNT_W-1:0]   pend_cnt_o,
  input logic [NUM_EVT-1:0] clr_vec
);
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (busy_o) cyc_q <= cyc_q + 1'b1;
    else             cyc_q <= '0;
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !link_o);  // R5

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(link_o));  // R5

  AST_BIT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (link_o != $past(link_o))) |-> ((cyc_q % BIT_DIV) == 0));  // R5

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (cyc_q == CYC_W'(FRAME_BITS * BIT_DIV)));  // R8

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (clr_vec == '0));  // R4

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));  // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt_o <= CNT_W'(NUM_EVT));  // R9
endmodule

bind evl_encoder evl_encoder_chk #(
  .NUM_EVT    (NUM_EVT),
  .BIT_DIV    (BIT_DIV),
  .FRAME_BITS (CODE_W + 3)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_o     (link_o),
  .busy_o     (busy_o),
  .pend_cnt_o (pend_cnt_o),
  .clr_vec    (clr_vec)
);

// File: tb/evl_encoder_bench.sv
`timescale 1ns/1ps
module evl_encoder_bench;
  localparam int N  = 256;
  localparam int BD = 10;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic         sw_valid;
  logic [7:0]   sw_code;
  logic         link;
  logic         busy;
  logic [8:0]   pend_cnt;

  int errors = 0;
  int checks = 0;
  int rx_code [0:63];
  int rx_n   = 0;
  int rx_bad = 0;

  evl_encoder #(.NUM_EVT(N), .BANK(16), .BIT_DIV(BD)) u_evl_encoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .sw_valid_i (sw_valid),
    .sw_code_i  (sw_code),
    .link_o     (link),
    .busy_o     (busy),
    .pend_cnt_o (pend_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // link receiver: sample each bit in its middle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && link === 1'b0) begin
        int code;
        int ones;
        bit start_ok;
        bit par;
        bit stp;
        code = 0;
        repeat (BD / 2 - 1) @(negedge clk);
        start_ok = (link == 1'b0);
        for (int i = 0; i < 8; i++) begin
          repeat (BD) @(negedge clk);
          code = (code << 1) | int'(link);
        end
        repeat (BD) @(negedge clk);
        par = link;
        repeat (BD) @(negedge clk);
        stp = link;
        ones = $countones(code) + int'(par);
        if (!start_ok || !stp || (ones % 2) != 1) rx_bad++;
        if (rx_n < 64) rx_code[rx_n] = code;
        rx_n++;
      end
    end
  end

  task automatic wait_idle();
    repeat (8) @(negedge clk);
    while (busy || pend_cnt != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_busy();
    while (!busy) @(negedge clk);
  endtask

  task automatic pulse_hw(input logic [N-1:0] mask);
    @(negedge clk);
    req = req | mask;
    @(negedge clk);
    req = req & ~mask;
  endtask

  task automatic exp_code(input int idx, input int exp, input string rq);
    chk(idx < rx_n && rx_code[idx] == exp, rq, (idx < rx_n) ? rx_code[idx] : -1, exp);
  endtask

  task automatic t_reset();
    chk(link == 1'b1, "R10 link idle", int'(link), 1);
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    chk(pend_cnt == 0, "R10 pend_cnt", int'(pend_cnt), 0);
  endtask

  task automatic t_single();
    int base = rx_n;
    int bad0 = rx_bad;
    pulse_hw(N'(1) << 37);
    wait_idle();
    chk(rx_n == base + 1, "R1 one slot", rx_n - base, 1);
    exp_code(base, 37, "R5 code 37");
    chk(rx_bad == bad0, "R5 framing/parity", rx_bad - bad0, 0);
    chk(link == 1'b1, "R10 idle high after slot", int'(link), 1);
  endtask

  task automatic t_bank_order();
    int base = rx_n;
    pulse_hw((N'(1) << 255) | (N'(1) << 16) | (N'(1) << 15) | N'(1));
    wait_idle();
    exp_code(base,     0,   "R3 first");
    exp_code(base + 1, 15,  "R3 second");
    exp_code(base + 2, 16,  "R3 third");
    exp_code(base + 3, 255, "R3 fourth");
  endtask

  task automatic t_nonpreempt();
    int base = rx_n;
    pulse_hw(N'(1) << 100);
    wait_busy();
    repeat (15) @(negedge clk);
    pulse_hw(N'(1) << 3);
    wait_idle();
    exp_code(base,     100, "R4 running slot kept");
    exp_code(base + 1, 3,   "R4 higher waits");
  endtask

  task automatic t_overlap_count();
    int base = rx_n;
    pulse_hw(N'(1) << 10);
    wait_busy();
    pulse_hw((N'(1) << 40) | (N'(1) << 20) | (N'(1) << 30));
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R9 still in slot", int'(busy), 1);
    chk(pend_cnt == 3, "R9 pend_cnt mid slot", int'(pend_cnt), 3);
    wait_idle();
    chk(pend_cnt == 0, "R9 pend_cnt drained", int'(pend_cnt), 0);
    exp_code(base + 1, 20, "R7 kept a");
    exp_code(base + 2, 30, "R7 kept b");
    exp_code(base + 3, 40, "R7 kept c");
  endtask

  task automatic t_software();
    int base = rx_n;
    @(negedge clk);
    sw_valid = 1'b1;
    sw_code  = 8'hA5;
    @(negedge clk);
    sw_valid = 1'b0;
    wait_idle();
    exp_code(base, 165, "R2 sw code");
    base = rx_n;
    pulse_hw(N'(1) << 10);
    wait_busy();
    @(negedge clk);
    req[50]  = 1'b1;
    sw_valid = 1'b1;
    sw_code  = 8'd50;
    @(negedge clk);
    req[50]  = 1'b0;
    sw_valid = 1'b0;
    wait_idle();
    chk(rx_n == base + 2, "R2 merged sw+hw", rx_n - base, 2);
    exp_code(base + 1, 50, "R2 merged code");
  endtask

  task automatic t_requeue();
    int base = rx_n;
    pulse_hw(N'(1) << 77);
    wait_busy();
    repeat (20) @(negedge clk);
    pulse_hw(N'(1) << 77);
    wait_idle();
    chk(rx_n == base + 2, "R6 resent count", rx_n - base, 2);
    exp_code(base + 1, 77, "R6 resent code");
  endtask

  task automatic t_frame_len();
    int len = 0;
    pulse_hw(N'(1) << 200);
    wait_busy();
    while (busy) begin
      len++;
      @(negedge clk);
    end
    chk(len == 11 * BD, "R8 busy length", len, 11 * BD);
    wait_idle();
  endtask

  task automatic t_level();
    int base = rx_n;
    @(negedge clk);
    req[60] = 1'b1;
    repeat (300) @(negedge clk);
    req[60] = 1'b0;
    wait_idle();
    chk(rx_n == base + 1, "R1 level gives one", rx_n - base, 1);
    exp_code(base, 60, "R1 level code");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    req      = '0;
    sw_valid = 1'b0;
    sw_code  = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_bank_order();
    t_nonpreempt();
    t_overlap_count();
    t_software();
    t_requeue();
    t_frame_len();
    t_level();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule